// File: doc/BRIEF.md
# Serially Loaded Control Latch

This block holds a small set of board control bits, such as an audio mute or a video decoder disable, that a host sets through three slow general-purpose lines: a serial data line, a shift clock and a load strobe. The host presents each bit while the shift clock is low and then raises the clock. The block captures one bit on each rising shift-clock edge into a shift register, most significant bit first. Nothing reaches the outputs until the host pulses the load strobe. On the rising edge of that strobe the shift register is copied into the parallel output latch.

The three lines are asynchronous to the block clock. Each passes through a two-flop synchronizer, and the rising edges are then detected in the block clock domain. The host must hold every level for several block clock cycles. A load after fewer or more than the nominal number of shift clocks latches whatever the last register-width bits were.

Top module: `bsl_ctl_latch`

## Requirements
- R1: Reset (rst_n low) clears both the output latch and the shift register to zero. A load with no shift clocks after reset therefore gives ctl_q = 0.
- R2: A rising edge on ser_clk_i shifts the synchronized ser_data_i into bit 0 and moves every other bit up by one position. After WIDTH bits and a load, ctl_q[WIDTH-1] holds the first bit sent and ctl_q[0] holds the last.
- R3: ctl_q changes only in response to a rising edge of ser_load_i. It does not change while bits are shifting, and it does not change on the falling edge of the strobe.
- R4: After fewer than WIDTH shift clocks since the previous load, a load latches a value whose low positions are the new bits and whose upper positions are the older bits moved up. A load does not clear the shift register.
- R5: After more than WIDTH shift clocks, a load latches the last WIDTH bits shifted in.
- R6: Changes on ser_data_i while ser_clk_i is held high or low, and falling edges of ser_clk_i, leave the shift register unchanged.
- R7: Repeated loads with no shift clocks between them latch the same value each time.
- R8: When ser_load_i rises, ctl_q takes its new value at the third rising edge of clk after the input change (two synchronizer stages plus the edge register). ctl_q is unchanged after the first two edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_data_i | input | 1 | Serial data bit, asynchronous |
| ser_clk_i | input | 1 | Shift clock; rising edge captures a bit, asynchronous |
| ser_load_i | input | 1 | Load strobe; rising edge updates the outputs, asynchronous |
| ctl_q | output | WIDTH | Latched parallel control bits |

## Verification
The assertions assume that each serial line holds every level for at least two block clock cycles, so that each transition produces exactly one internal edge pulse. They also assume the data line is already stable when the shift clock rises. The bench drives every input at falling clock edges and holds each phase for four block cycles. It changes data only while no shift-clock edge is pending, so every transition reaches the synchronizers cleanly and the single-pulse and capture properties stay within their premise.

// File: rtl/bsl_pkg.sv
package bsl_pkg;
  // lane positions of the raw serial lines inside the synchronizer vector
  localparam int LANE_DATA  = 0;
  localparam int LANE_CLK   = 1;
  localparam int LANE_LOAD  = 2;
  localparam int LANES      = 3;
  // lanes that need a rising-edge detector (shift clock and load strobe)
  localparam int EDGE_LANES = 2;
  localparam int EDGE_BASE  = LANE_CLK;
endpackage

// File: rtl/bsl_sync.sv
module bsl_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] sync_o
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0][N-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= {stage_q[LAST-1:0], async_i};
  end

  assign sync_o = stage_q[LAST];
endmodule

// File: rtl/bsl_rise.sv
module bsl_rise (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level_i;
  end

  assign rise_o = level_i & ~prev_q;
endmodule

// File: rtl/bsl_shifter.sv
module bsl_shifter #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             bit_in,
  output logic [WIDTH-1:0] sr_q
);
  // new bit enters at the bottom; the oldest bit leaves at the top
  function automatic logic [WIDTH-1:0] push_bit(input logic [WIDTH-1:0] cur,
                                                input logic b);
    return {cur[WIDTH-2:0], b};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sr_q <= '0;
    else if (shift_en) sr_q <= push_bit(sr_q, bit_in);
  end
endmodule

// File: rtl/bsl_latch.sv
module bsl_latch #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= '0;
    else if (load_en) q <= d;
  end
endmodule

// File: rtl/bsl_ctl_latch.sv
module bsl_ctl_latch #(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_data_i,
  input  logic             ser_clk_i,
  input  logic             ser_load_i,
  output logic [WIDTH-1:0] ctl_q
);
  import bsl_pkg::*;

  logic [LANES-1:0]      raw_v;
  logic [LANES-1:0]      lvl_v;
  logic [EDGE_LANES-1:0] edge_v;

  // named internal events, used by the bound checker
  logic             data_s;
  logic             shift_rise;
  logic             load_rise;
  logic [WIDTH-1:0] shift_q;

  always_comb begin
    raw_v            = '0;
    raw_v[LANE_DATA] = ser_data_i;
    raw_v[LANE_CLK]  = ser_clk_i;
    raw_v[LANE_LOAD] = ser_load_i;
  end

  bsl_sync #(.N(LANES), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (raw_v),
    .sync_o  (lvl_v)
  );

  for (genvar g = 0; g < EDGE_LANES; g++) begin : g_edge
    bsl_rise u_rise (
      .clk     (clk),
      .rst_n   (rst_n),
      .level_i (lvl_v[EDGE_BASE + g]),
      .rise_o  (edge_v[g])
    );
  end

  assign data_s     = lvl_v[LANE_DATA];
  assign shift_rise = edge_v[LANE_CLK - EDGE_BASE];
  assign load_rise  = edge_v[LANE_LOAD - EDGE_BASE];

  bsl_shifter #(.WIDTH(WIDTH)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_rise),
    .bit_in   (data_s),
    .sr_q     (shift_q)
  );

  bsl_latch #(.WIDTH(WIDTH)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (load_rise),
    .d       (shift_q),
    .q       (ctl_q)
  );
endmodule

// File: rtl/bsl_ctl_latch_chk.sv
module bsl_ctl_latch_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             data_s,
  input logic             shift_rise,
  input logic             load_rise,
  input logic [WIDTH-1:0] shift_q,
  input logic [WIDTH-1:0] ctl_q
);
  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (ctl_q == '0 && shift_q == '0));

  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    shift_rise |=> shift_q == {$past(shift_q[WIDTH-2:0]), $past(data_s)});

  a_r6_hold_without_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_rise |=> $stable(shift_q));

  a_r3_only_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    !load_rise |=> $stable(ctl_q));

  a_r3_copy_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_rise |=> ctl_q == $past(shift_q));

  a_r8_load_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    load_rise |=> !load_rise);

  a_r2_shift_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    shift_rise |=> !shift_rise);
endmodule

bind bsl_ctl_latch bsl_ctl_latch_chk #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .data_s     (data_s),
  .shift_rise (shift_rise),
  .load_rise  (load_rise),
  .shift_q    (shift_q),
  .ctl_q      (ctl_q)
);

// File: tb/tb_bsl_ctl_latch.sv
module tb_bsl_ctl_latch;
  localparam int W    = 4;
  localparam int MASK = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ser_data = 1'b0;
  logic         ser_clk = 1'b0;
  logic         ser_load = 1'b0;
  logic [W-1:0] ctl_q;

  int errors = 0;
  int checks = 0;
  int exp_sr = 0;   // expected shift register contents
  int exp_ctl = 0;  // expected latched output

  always #5 clk = ~clk;

  bsl_ctl_latch #(.WIDTH(W), .SYNC_STAGES(2)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .ser_data_i (ser_data),
    .ser_clk_i  (ser_clk),
    .ser_load_i (ser_load),
    .ctl_q      (ctl_q)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: ctl_q=%0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one bit: data while clock low, then a clock high phase, then back low
  task automatic send_bit(input int b);
    ser_data = b[0];
    wait_cyc(4);
    ser_clk = 1'b1;
    wait_cyc(4);
    ser_clk = 1'b0;
    wait_cyc(4);
    exp_sr = ((exp_sr * 2) + (b & 1)) % (MASK + 1);
    chk("R3 no change while shifting", int'(ctl_q), exp_ctl);
  endtask

  task automatic do_load(input string req);
    ser_data = 1'b0;
    ser_load = 1'b1;
    wait_cyc(4);
    exp_ctl = exp_sr;
    chk(req, int'(ctl_q), exp_ctl);
    ser_load = 1'b0;
    wait_cyc(4);
    chk("R3 falling strobe no effect", int'(ctl_q), exp_ctl);
  endtask

  task automatic send_word(input int v, input int nbits);
    for (int i = nbits - 1; i >= 0; i--) send_bit((v >> i) & 1);
  endtask

  initial begin
    wait_cyc(3);
    chk("R1 reset output", int'(ctl_q), 0);
    rst_n = 1'b1;
    wait_cyc(2);
    do_load("R1 shift register cleared");

    // R2: every value, most significant bit first
    for (int v = 0; v <= MASK; v++) begin
      send_word(v, W);
      do_load("R2 exhaustive value");
      chk("R2 value order", int'(ctl_q), v);
    end

    // R4: short sequences, 1..W-1 bits, on top of the previous contents
    for (int n = 1; n < W; n++) begin
      send_word(n, n);
      do_load("R4 fewer bits keep older ones");
    end

    // R5: longer sequences, last W bits win
    send_word(6'b101100, 6);
    do_load("R5 more bits");
    chk("R5 last four", int'(ctl_q), 4'hC);
    send_word(7'b0110011, 7);
    do_load("R5 more bits second");

    // R6: data toggles with no rising shift clock edge
    ser_data = 1'b1;
    wait_cyc(4);
    ser_clk = 1'b1;
    wait_cyc(4);
    for (int k = 0; k < 4; k++) begin ser_data = ~ser_data; wait_cyc(3); end
    ser_clk = 1'b0;
    wait_cyc(4);
    for (int k = 0; k < 5; k++) begin ser_data = ~ser_data; wait_cyc(3); end
    exp_sr = ((exp_sr * 2) + 1) % (MASK + 1);
    do_load("R6 only one bit captured");

    // R7: repeated loads
    do_load("R7 repeat load");
    do_load("R7 repeat load again");

    // R8: exact latency from strobe rise to output update
    send_word(exp_ctl ^ MASK, W);
    ser_load = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    chk("R8 unchanged after two edges", int'(ctl_q), exp_ctl);
    @(posedge clk); #1;
    exp_ctl = exp_sr;
    chk("R8 updated on third edge", int'(ctl_q), exp_ctl);
    @(negedge clk);
    ser_load = 1'b0;
    wait_cyc(4);

    // R1: reset in mid run with nonzero shift contents
    send_word(4'h9, W);
    rst_n = 1'b0;
    wait_cyc(2);
    chk("R1 reset mid run", int'(ctl_q), 0);
    rst_n = 1'b1;
    exp_sr = 0;
    exp_ctl = 0;
    wait_cyc(2);
    do_load("R1 load after reset");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog: ctl_q=%0h expected completion", ctl_q);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule